// File: doc/BRIEF.md
# Bus-Window Control Register with Address Extension

This block is a single 32-bit local control register whose meaning depends on the direction of the access. A write sets 16 active-low indicator outputs and two active-low reset controls for an external bus-interface controller. It also loads the upper 11 bits of a 32-bit backplane address, a 2-bit address-size code and a data-width select. A read does not return the written value. It returns six 2-bit memory-socket size codes taken from strap inputs, and the unused upper bits read as zero.

The block also performs address extension for a 2-Mbyte local window, which sits at base 0x00E00000 by default. During a local access that falls inside the window, the backplane address is built from two parts. The upper 11 bits come from the stored register field. The low 21 bits come from the local address of that access. Software reaches any 2-Mbyte region of the 4-Gbyte backplane space by writing the register once and then accessing the window.

The two reset controls pass through a staging rule enforced in hardware. The qualifier can only be asserted while the internal reset is held. The internal reset can only be released once the qualifier is released. As a result, a global reset always goes through separate assert and release steps.

Top module: `bus_window_ctrl`

## Requirements
- R1: After reset all indicators are dark (`led_n` = 0xFFFF) and both reset controls are released (`ctl_irst_n` = 1, `ctl_qual_n` = 1). The upper-address field is all ones, the address-size code is 2'b11 and the width select is 1.
- R2: A full write drives `led_n[i]` from write bit i for bits 0..15. A 0 lights the indicator.
- R3: A register write is taken only when `reg_sel`, `reg_we` and all four `reg_be` bits are 1. A write with any byte enable at 0 leaves every output unchanged.
- R4: Write bit 16 = 0 asserts the internal reset (`ctl_irst_n` = 0) from the next cycle.
- R5: Write bit 17 = 0 asserts the qualifier (`ctl_qual_n` = 0) only if the internal reset was already asserted before the write and bit 16 of the same write is also 0. Otherwise the qualifier is released. A write that clears both bits from the idle state asserts only the internal reset.
- R6: A write with bit 16 = 1 releases the internal reset only if the qualifier was already released before the write. A single write that sets both bits while both are asserted releases only the qualifier.
- R7: Write bits 28..18 give backplane address bits 31..21. Bits 30..29 give `bp_asize[1:0]` (bit 29 goes to `bp_asize[0]`). Bit 31 gives `bp_wide`, where 0 means 16-bit transfers and 1 means 32-bit transfers.
- R8: A read (`reg_sel` = 1, `reg_we` = 0) returns `size_strap[11:0]` in bits 11..0 and zero in bits 31..12. Socket k's code is in bits 2k-1..2k-2, with sockets 1–4 private and sockets 5–6 shared. The codes are 00 = 1 Mbyte, 01 = 256 Kbytes, 10 = 64 Kbytes and 11 = empty. When no read is in progress, `reg_rdata` is 0.
- R9: `bp_valid` is 1 exactly when `loc_req` is 1 and `loc_addr[31:21]` equals the window base bits 31..21. In that case `bp_addr` = {upper field, `loc_addr[20:0]`}.
- R10: During a window access held over consecutive cycles, `bp_addr[31:21]`, `bp_asize` and `bp_wide` keep the values they had in the first cycle of the access, even if the register is written meanwhile. The low 21 bits still follow `loc_addr`.
- R11: Writing 0xA703FFFF and then accessing local address 0x00E04000 gives `bp_addr` = 0x38004000, `bp_asize` = 2'b01, `bp_wide` = 1 and all indicators dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register selected for access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_be | input | 4 | Byte enables; all must be set for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (socket size codes) |
| size_strap | input | 12 | Six 2-bit socket size straps |
| loc_req | input | 1 | Local access in progress |
| loc_addr | input | 32 | Local address of the access |
| bp_valid | output | 1 | Access falls inside the window |
| bp_addr | output | 32 | Extended backplane address |
| bp_asize | output | 2 | Address-size select lines |
| bp_wide | output | 1 | Data width select (1 = 32-bit) |
| led_n | output | 16 | Active-low indicator outputs |
| ctl_irst_n | output | 1 | Active-low internal reset to controller |
| ctl_qual_n | output | 1 | Active-low reset qualifier to controller |

## Verification
The reset controls are driven through the correct four-step staging sequence and also through the forbidden shortcuts: assert both from idle, and release both in one write. This separates a design that follows the staging rule from one that copies the write bits straight through. The address path is tested with the worked A32/D32 example and with addresses just inside and just outside both window edges. It is also tested with a register write made while a window access is held, which separates a snapshot taken at the start of the access from a live pass-through. A long random phase mixes partial and full writes, reads with varied straps, and window and non-window accesses. A cycle-by-cycle model checks every output on every clock.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int LCR_W       = 32;
  localparam int ADDR_W      = 32;
  localparam int LED_W       = 16;
  localparam int UPPER_W     = 11;
  localparam int ASIZE_W     = 2;
  localparam int SOCK_N      = 6;
  localparam int SOCK_CODE_W = 2;
  localparam int STRAP_W     = SOCK_N * SOCK_CODE_W;
  localparam int LOW_W       = ADDR_W - UPPER_W;

  // Field placement inside the written word (the positions carry meaning)
  localparam int IRST_BIT  = LED_W;
  localparam int QUAL_BIT  = LED_W + 1;
  localparam int UPPER_LSB = LED_W + 2;
  localparam int ASIZE_LSB = UPPER_LSB + UPPER_W;
  localparam int WIDE_BIT  = ASIZE_LSB + ASIZE_W;

  typedef struct packed {
    logic [UPPER_W-1:0] upper;
    logic [ASIZE_W-1:0] asize;
    logic               wide;
  } bp_attr_t;

  localparam bp_attr_t ATTR_RST = '{upper: '1, asize: '1, wide: 1'b1};
endpackage

// File: rtl/lcr_rst_sync.sv
module lcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/lcr_ctrl_reg.sv
module lcr_ctrl_reg
  import lcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LCR_W-1:0] wdata,
  output logic [LED_W-1:0] led_n,
  output logic             irst_n,
  output logic             qual_n,
  output bp_attr_t         attr
);
  logic [LED_W-1:0] led_q, led_d;
  logic             irst_q, irst_d;
  logic             qual_q, qual_d;
  bp_attr_t         attr_q, attr_d;
  logic             w_irst, w_qual;

  assign w_irst = wdata[IRST_BIT];
  assign w_qual = wdata[QUAL_BIT];

  // Next state: plain fields load directly, reset controls are staged
  always_comb begin
    led_d        = wdata[LED_W-1:0];
    attr_d.upper = wdata[UPPER_LSB +: UPPER_W];
    attr_d.asize = wdata[ASIZE_LSB +: ASIZE_W];
    attr_d.wide  = wdata[WIDE_BIT];
    // Release of the internal reset waits for the qualifier to be released
    irst_d       = w_irst & qual_q;
    // Qualifier asserts only while internal reset is held before and after
    qual_d       = w_qual | irst_q | w_irst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '1;
      irst_q <= 1'b1;
      qual_q <= 1'b1;
      attr_q <= ATTR_RST;
    end else if (wr_en) begin
      led_q  <= led_d;
      irst_q <= irst_d;
      qual_q <= qual_d;
      attr_q <= attr_d;
    end
  end

  assign led_n  = led_q;
  assign irst_n = irst_q;
  assign qual_n = qual_q;
  assign attr   = attr_q;

  assert_qual_needs_irst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qual_q) |-> !$past(irst_q));

  assert_no_joint_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irst_q) |-> $past(qual_q));

  assert_qual_inside_irst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_q |-> !irst_q);
endmodule

// File: rtl/lcr_strap_read.sv
module lcr_strap_read
  import lcr_pkg::*;
(
  input  logic               rd_en,
  input  logic [STRAP_W-1:0] strap,
  output logic [LCR_W-1:0]   rdata
);
  for (genvar s = 0; s < SOCK_N; s++) begin : g_sock
    assign rdata[s*SOCK_CODE_W +: SOCK_CODE_W] =
      rd_en ? strap[s*SOCK_CODE_W +: SOCK_CODE_W] : '0;
  end

  assign rdata[LCR_W-1:STRAP_W] = '0;
endmodule

// File: rtl/lcr_window.sv
module lcr_window
  import lcr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h00E0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bp_attr_t           attr_live,
  input  logic               loc_req,
  input  logic [ADDR_W-1:0]  loc_addr,
  output logic               bp_valid,
  output logic [ADDR_W-1:0]  bp_addr,
  output logic [ASIZE_W-1:0] bp_asize,
  output logic               bp_wide
);
  logic     hit;
  logic     active_q, active_d;
  logic     snap_en;
  bp_attr_t snap_q, snap_d;
  bp_attr_t attr_sel;

  assign hit = (loc_addr[ADDR_W-1:LOW_W] == WIN_BASE[ADDR_W-1:LOW_W]);

  always_comb begin
    bp_valid = loc_req & hit;
    active_d = bp_valid;
    snap_en  = bp_valid & ~active_q;
    snap_d   = attr_live;
    attr_sel = active_q ? snap_q : attr_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= ATTR_RST;
    end else if (snap_en) begin
      snap_q <= snap_d;
    end
  end

  assign bp_addr  = {attr_sel.upper, loc_addr[LOW_W-1:0]};
  assign bp_asize = attr_sel.asize;
  assign bp_wide  = attr_sel.wide;

  assert_hold_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_valid && $past(bp_valid)) |->
      ($stable(bp_addr[ADDR_W-1:LOW_W]) && $stable(bp_asize) && $stable(bp_wide)));

  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_req |-> !bp_valid);
endmodule

// File: rtl/bus_window_ctrl.sv
module bus_window_ctrl
  import lcr_pkg::*;
#(
  parameter logic [31:0] WIN_BASE    = 32'h00E0_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [11:0] size_strap,
  input  logic        loc_req,
  input  logic [31:0] loc_addr,
  output logic        bp_valid,
  output logic [31:0] bp_addr,
  output logic [1:0]  bp_asize,
  output logic        bp_wide,
  output logic [15:0] led_n,
  output logic        ctl_irst_n,
  output logic        ctl_qual_n
);
  logic     rst_sn;
  logic     wr_en;
  logic     rd_en;
  bp_attr_t attr_live;

  assign wr_en = reg_sel & reg_we & (&reg_be);
  assign rd_en = reg_sel & ~reg_we;

  lcr_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_sn)
  );

  lcr_ctrl_reg i_ctrl (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (wr_en),
    .wdata  (reg_wdata),
    .led_n  (led_n),
    .irst_n (ctl_irst_n),
    .qual_n (ctl_qual_n),
    .attr   (attr_live)
  );

  lcr_strap_read i_read (
    .rd_en (rd_en),
    .strap (size_strap),
    .rdata (reg_rdata)
  );

  lcr_window #(.WIN_BASE(WIN_BASE)) i_win (
    .clk       (clk),
    .rst_n     (rst_sn),
    .attr_live (attr_live),
    .loc_req   (loc_req),
    .loc_addr  (loc_addr),
    .bp_valid  (bp_valid),
    .bp_addr   (bp_addr),
    .bp_asize  (bp_asize),
    .bp_wide   (bp_wide)
  );

  assert_partial_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_sel && reg_we && reg_be != 4'hF) |=>
      ($stable(led_n) && $stable(ctl_irst_n) && $stable(ctl_qual_n)));

  assert_read_high_zero_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_rdata[31:12] == 20'h0);
endmodule

// File: tb/test_bus_window_ctrl.sv
`timescale 1ns/1ps
module test_bus_window_ctrl;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        reg_sel, reg_we;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic [11:0] size_strap;
  logic        loc_req;
  logic [31:0] loc_addr;
  logic        bp_valid, bp_wide, ctl_irst_n, ctl_qual_n;
  logic [31:0] bp_addr;
  logic [1:0]  bp_asize;
  logic [15:0] led_n;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit cmp_on  = 1'b0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bus_window_ctrl i_bus_window_ctrl (
    .clk(clk), .arst_n(arst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .size_strap(size_strap), .loc_req(loc_req), .loc_addr(loc_addr),
    .bp_valid(bp_valid), .bp_addr(bp_addr), .bp_asize(bp_asize),
    .bp_wide(bp_wide), .led_n(led_n), .ctl_irst_n(ctl_irst_n),
    .ctl_qual_n(ctl_qual_n)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_led;
  logic        m_irst_n, m_qual_n, m_wd, s_wd, m_act;
  logic [10:0] m_up, s_up;
  logic [1:0]  m_as, s_as;

  function automatic bit in_win(input logic [31:0] a);
    return (a >= 32'h00E0_0000) && (a <= 32'h00FF_FFFF);
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_led <= 16'hFFFF; m_irst_n <= 1'b1; m_qual_n <= 1'b1;
      m_up <= 11'h7FF; m_as <= 2'b11; m_wd <= 1'b1;
      s_up <= 11'h7FF; s_as <= 2'b11; s_wd <= 1'b1; m_act <= 1'b0;
    end else begin
      if (loc_req && in_win(loc_addr) && !m_act) begin
        s_up <= m_up; s_as <= m_as; s_wd <= m_wd;
      end
      m_act <= loc_req && in_win(loc_addr);
      if (reg_sel && reg_we && reg_be == 4'hF) begin
        m_led <= reg_wdata[15:0];
        m_up  <= reg_wdata[28:18];
        m_as  <= reg_wdata[30:29];
        m_wd  <= reg_wdata[31];
        if (!reg_wdata[16]) m_irst_n <= 1'b0;
        else if (m_qual_n)  m_irst_n <= 1'b1;
        if (!reg_wdata[17] && !reg_wdata[16] && !m_irst_n) m_qual_n <= 1'b0;
        else m_qual_n <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      bad_cnt++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [10:0] eu; logic [1:0] ea; logic ew;
      eu = m_act ? s_up : m_up;
      ea = m_act ? s_as : m_as;
      ew = m_act ? s_wd : m_wd;
      chk("R2", "led_n", {16'h0, led_n}, {16'h0, m_led});
      chk("R4", "irst_n", {31'h0, ctl_irst_n}, {31'h0, m_irst_n});
      chk("R5/R6", "qual_n", {31'h0, ctl_qual_n}, {31'h0, m_qual_n});
      chk("R9", "bp_valid", {31'h0, bp_valid}, {31'h0, loc_req && in_win(loc_addr)});
      chk("R10", "bp_addr", bp_addr, {eu, loc_addr[20:0]});
      chk("R7", "asize/wide", {29'h0, bp_asize, bp_wide}, {29'h0, ea, ew});
      chk("R8", "rdata", reg_rdata,
          (reg_sel && !reg_we) ? {20'h0, size_strap} : 32'h0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    reg_sel = 1'b1; reg_we = 1'b1; reg_be = be; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 1'b0; reg_we = 1'b0; reg_be = 4'h0;
    @(negedge clk);
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    bad_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_be = 4'h0;
    reg_wdata = 32'h0; size_strap = 12'h000; loc_req = 1'b0; loc_addr = 32'h0;
    #11 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 cmp_on = 1'b1;

    // R1: reset state, window shows the all-ones upper field
    loc_req = 1'b1; loc_addr = 32'h00E0_0010;
    @(negedge clk);
    chk("R1", "led_n reset", {16'h0, led_n}, 32'h0000_FFFF);
    chk("R1", "resets released", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h3);
    chk("R1", "bp_addr reset", bp_addr, 32'hFFE0_0010);
    chk("R1", "asize/wide reset", {29'h0, bp_asize, bp_wide}, 32'h7);
    step(); loc_req = 1'b0;

    // R2: indicator patterns
    wr(32'hFFFF_A55A, 4'hF);
    chk("R2", "led A55A", {16'h0, led_n}, 32'h0000_A55A);
    wr(32'hFFFF_00FF, 4'hF);
    chk("R2", "led 00FF", {16'h0, led_n}, 32'h0000_00FF);

    // R3: partial strobes ignored
    wr(32'h0000_0000, 4'h7);
    chk("R3", "led after be=7", {16'h0, led_n}, 32'h0000_00FF);
    wr(32'h0000_0000, 4'h8);
    chk("R3", "irst after be=8", {31'h0, ctl_irst_n}, 32'h1);

    // R4/R5: correct staging sequence
    wr(32'hFFFE_FFFF, 4'hF);
    chk("R4", "irst asserted", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h1);
    wr(32'hFFFC_FFFF, 4'hF);
    chk("R5", "qual asserted", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h0);
    wr(32'hFFFD_FFFF, 4'hF);
    chk("R5", "qual released", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h1);
    wr(32'hFFFF_FFFF, 4'hF);
    chk("R4", "irst released", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h3);

    // R5: qualifier alone from idle, then both from idle
    wr(32'hFFFD_FFFF, 4'hF);
    chk("R5", "qual blocked idle", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h3);
    wr(32'hFFFC_FFFF, 4'hF);
    chk("R5", "both from idle", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h1);
    wr(32'hFFFC_FFFF, 4'hF);
    chk("R5", "qual second step", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h0);

    // R6: joint release only releases the qualifier
    wr(32'hFFFF_FFFF, 4'hF);
    chk("R6", "joint release", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h1);
    wr(32'hFFFF_FFFF, 4'hF);
    chk("R6", "irst release later", {30'h0, ctl_irst_n, ctl_qual_n}, 32'h3);

    // R11/R7: worked example
    wr(32'hA703_FFFF, 4'hF);
    step(); loc_req = 1'b1; loc_addr = 32'h00E0_4000;
    @(negedge clk);
    chk("R11", "bp_addr example", bp_addr, 32'h3800_4000);
    chk("R11", "asize/wide example", {29'h0, bp_asize, bp_wide}, 32'h3);
    chk("R11", "led dark", {16'h0, led_n}, 32'h0000_FFFF);
    chk("R11", "valid", {31'h0, bp_valid}, 32'h1);

    // R10: write during a held access
    wr(32'h4003_FFFF, 4'hF);
    chk("R10", "upper held", bp_addr, 32'h3800_4000);
    chk("R10", "width held", {29'h0, bp_asize, bp_wide}, 32'h3);
    step(); loc_addr = 32'h00F0_0004;
    @(negedge clk);
    chk("R10", "low follows", bp_addr, 32'h3810_0004);
    step(); loc_req = 1'b0;
    step(); loc_req = 1'b1;
    @(negedge clk);
    chk("R7", "new upper", bp_addr, 32'h0010_0004);
    chk("R7", "new asize/wide", {29'h0, bp_asize, bp_wide}, 32'h4);

    // R9: window edges
    step(); loc_addr = 32'h00DF_FFFC;
    @(negedge clk);
    chk("R9", "below base", {31'h0, bp_valid}, 32'h0);
    step(); loc_addr = 32'h0100_0000;
    @(negedge clk);
    chk("R9", "above top", {31'h0, bp_valid}, 32'h0);
    step(); loc_addr = 32'hE0E0_0000;
    @(negedge clk);
    chk("R9", "alias high bits", {31'h0, bp_valid}, 32'h0);
    step(); loc_addr = 32'h00FF_FFFC;
    @(negedge clk);
    chk("R9", "top edge hit", {31'h0, bp_valid}, 32'h1);
    chk("R9", "top edge addr", bp_addr, 32'h001F_FFFC);
    step(); loc_req = 1'b0;

    // R8: strap reads
    step(); reg_sel = 1'b1; reg_we = 1'b0; size_strap = 12'hE4B;
    @(negedge clk);
    chk("R8", "mixed codes", reg_rdata, 32'h0000_0E4B);
    step(); size_strap = 12'hFFF;
    @(negedge clk);
    chk("R8", "all sockets empty", reg_rdata, 32'h0000_0FFF);
    step(); size_strap = 12'h000;
    @(negedge clk);
    chk("R8", "all 1 Mbyte", reg_rdata, 32'h0);
    step(); reg_sel = 1'b0; size_strap = 12'h5A5;
    @(negedge clk);
    chk("R8", "no read", reg_rdata, 32'h0);

    // Random mix checked by the model every clock
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      step();
      r = $urandom;
      reg_sel    = (r[1:0] == 2'b00);
      reg_we     = r[2];
      reg_be     = r[4:3] == 2'b00 ? r[8:5] : 4'hF;
      reg_wdata  = $urandom;
      size_strap = r[20:9];
      loc_req    = r[21] | r[22];
      case (r[24:23])
        2'd0: loc_addr = 32'h00E0_0000 | {11'h0, r[31:11]};
        2'd1: loc_addr = 32'h00E0_0000 + {12'h0, r[19:0]};
        2'd2: loc_addr = 32'h00DF_FFF0 + {28'h0, r[28:25]};
        default: loc_addr = $urandom;
      endcase
    end
    step();
    reg_sel = 1'b0; reg_we = 1'b0; loc_req = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule